// File: doc/BRIEF.md
# Manual Encryption Request Sequencer

This block runs one software-driven encryption request on the write path to external flash. Software fills a plaintext buffer of up to 64 bytes, chooses how many bytes form one line (16, 32 or 64), sets a target bit and a 26-bit physical flash address, and then issues three commands in turn: start, publish and wipe. The block checks each command against its four-step status, hands the operands to an external cipher engine through a start pulse and a done strobe, and holds the returned ciphertext hidden until software publishes it to the memory-interface side.

Every command is honoured in exactly one status value. A command that arrives in any other status, or a start issued with illegal operands, is dropped and sets a sticky error flag. Wiping a published result zeroes the stored ciphertext and returns the block to idle. All accesses use a simple word bus with byte strobes. Reads are combinational from the bus address.

Top module: `mcrypt_seq`

## Requirements
- R1: After reset the status reads 0 (idle), the error flag is 0, the line-size code, target bit and address read 0, the guard level reads 7, and `res_valid` is 0.
- R2: Writing bit 0 (start) of the command word at 0x34C while the status is 0 with legal operands moves the status to 1. In the next cycle `eng_start` is high for exactly one cycle, with the stored plaintext, line-size code, target, address and guard level on the engine outputs. Plaintext byte i sits at bits [8i+7:8i] of `eng_plain`.
- R3: `eng_done` during status 1 captures `eng_result` and moves the status to 2. The result stays hidden: `res_valid` is 0 and `res_data` is 0. `eng_done` in any other status has no effect.
- R4: Writing bit 1 (publish) of the command word during status 2 moves the status to 3. `res_valid` then becomes 1 and `res_data` equals the captured result.
- R5: Writing bit 2 (wipe) of the command word during status 3 returns the status to 0, zeroes the stored result and drops `res_valid`.
- R6: A command bit written in any status other than its own leaves the status unchanged and sets the error flag, which is bit 2 of the status word at 0x350. The flag stays set until software writes 1 to that bit.
- R7: A start is rejected as in R6 if the line-size code (bits [1:0] at 0x340; 0=16, 1=32, 2=64 bytes) is 3, if the target bit (bit 0 at 0x344) is 1, or if the address (bits [25:0] at 0x348) is not a multiple of the selected line size.
- R8: The command word always reads back as zero.
- R9: The plaintext buffer occupies 0x300 to 0x33F. Bytes are written under the byte strobes and read back as words. Plaintext and parameter writes are ignored while the status is not 0. Parameter fields are written when strobe bit 0 is set.
- R10: The guard level is a 3-bit field at 0x354 that resets to 7 and is driven to the engine as `eng_level`. Level 0 means the engine runs without side-channel countermeasures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the cipher engine |
| eng_line_code | output | 2 | Line-size code |
| eng_target | output | 1 | Target bit |
| eng_addr | output | 26 | Physical flash address |
| eng_level | output | 3 | Guard level |
| eng_plain | output | 512 | Plaintext buffer contents |
| eng_done | input | 1 | Engine completion strobe |
| eng_result | input | 512 | Engine ciphertext |
| res_valid | output | 1 | Result published to the memory interface |
| res_data | output | 512 | Published result, zero unless published |

## Verification
The bench builds the block with its default parameters: a 64-byte buffer, a 26-bit address and a 3-bit guard level. With these values the full 64-byte line and the mid-range alignment bits of the address are both reachable. Random operands go through all three legal line sizes and every guard level. Each random pass also fires one command in a wrong state. Directed cases cover reserved operands, misalignment by a single bit, a stray done strobe while idle, and writes attempted during a busy calculation.

// File: rtl/mcrypt_seq.sv
module mcrypt_seq #(
  parameter int BUF_BYTES = 64,
  parameter int PADDR_W   = 26,
  parameter int LVL_W     = 3,
  parameter int AW        = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [3:0]             bus_be,
  output logic [31:0]            bus_rdata,
  output logic                   eng_start,
  output logic [1:0]             eng_line_code,
  output logic                   eng_target,
  output logic [PADDR_W-1:0]     eng_addr,
  output logic [LVL_W-1:0]       eng_level,
  output logic [BUF_BYTES*8-1:0] eng_plain,
  input  logic                   eng_done,
  input  logic [BUF_BYTES*8-1:0] eng_result,
  output logic                   res_valid,
  output logic [BUF_BYTES*8-1:0] res_data
);
  localparam int WORDS    = BUF_BYTES / 4;
  localparam int WIX_W    = $clog2(WORDS);
  localparam int BUF_BITS = BUF_BYTES * 8;
  localparam logic [AW-1:0] PT_BASE = AW'('h300);
  localparam logic [AW-1:0] PT_END  = AW'('h300 + BUF_BYTES);
  localparam logic [AW-1:0] A_LINE  = AW'('h340);
  localparam logic [AW-1:0] A_TGT   = AW'('h344);
  localparam logic [AW-1:0] A_ADDR  = AW'('h348);
  localparam logic [AW-1:0] A_CMD   = AW'('h34C);
  localparam logic [AW-1:0] A_STAT  = AW'('h350);
  localparam logic [AW-1:0] A_LVL   = AW'('h354);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_HIDDEN, S_SHOWN} st_t;

  st_t                 st;
  logic                err_q;
  logic [1:0]          line_q;
  logic                tgt_q;
  logic [PADDR_W-1:0]  addr_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [BUF_BITS-1:0] pt_q;
  logic [BUF_BITS-1:0] res_q;
  logic                start_q;

  logic [AW-1:0]    pt_off;
  logic [WIX_W-1:0] pt_widx;
  logic             pt_hit, idle, p_wr, aligned, ops_ok;
  logic             cmd_wr, go, pub, wipe, go_ok, pub_ok, wipe_ok, err_set, err_clr;

  assign idle    = (st == S_IDLE);
  assign pt_off  = bus_addr - PT_BASE;
  assign pt_widx = pt_off[WIX_W+1:2];
  assign pt_hit  = (bus_addr >= PT_BASE) && (bus_addr < PT_END);
  assign p_wr    = bus_we && idle && bus_be[0];

  always_comb begin
    case (line_q)
      2'd0:    aligned = (addr_q[3:0] == 4'd0);
      2'd1:    aligned = (addr_q[4:0] == 5'd0);
      2'd2:    aligned = (addr_q[5:0] == 6'd0);
      default: aligned = 1'b0;
    endcase
  end
  assign ops_ok = (line_q != 2'd3) && !tgt_q && aligned;

  assign cmd_wr  = bus_we && (bus_addr == A_CMD) && bus_be[0];
  assign go      = cmd_wr && bus_wdata[0];
  assign pub     = cmd_wr && bus_wdata[1];
  assign wipe    = cmd_wr && bus_wdata[2];
  assign go_ok   = go && idle && ops_ok;
  assign pub_ok  = pub && (st == S_HIDDEN);
  assign wipe_ok = wipe && (st == S_SHOWN);
  assign err_set = (go && !go_ok) || (pub && !pub_ok) || (wipe && !wipe_ok);
  assign err_clr = bus_we && (bus_addr == A_STAT) && bus_be[0] && bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      res_q   <= '0;
    end else begin
      start_q <= go_ok;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (go_ok)                          st <= S_BUSY;
      else if (st == S_BUSY && eng_done) st <= S_HIDDEN;
      else if (pub_ok)                    st <= S_SHOWN;
      else if (wipe_ok)                   st <= S_IDLE;
      if (st == S_BUSY && eng_done) res_q <= eng_result;
      else if (wipe_ok)             res_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      tgt_q  <= 1'b0;
      addr_q <= '0;
      lvl_q  <= '1;
    end else if (p_wr) begin
      if (bus_addr == A_LINE) line_q <= bus_wdata[1:0];
      if (bus_addr == A_TGT)  tgt_q  <= bus_wdata[0];
      if (bus_addr == A_ADDR) addr_q <= bus_wdata[PADDR_W-1:0];
      if (bus_addr == A_LVL)  lvl_q  <= bus_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pt_q <= '0;
    else if (bus_we && idle && pt_hit)
      for (int w = 0; w < WORDS; w++)
        if (pt_widx == w[WIX_W-1:0])
          for (int b = 0; b < 4; b++)
            if (bus_be[b]) pt_q[(w*4+b)*8 +: 8] <= bus_wdata[b*8 +: 8];
  end

  always_comb begin
    bus_rdata = '0;
    if (pt_hit)                  bus_rdata = pt_q[32*pt_widx +: 32];
    else if (bus_addr == A_LINE) bus_rdata = {30'd0, line_q};
    else if (bus_addr == A_TGT)  bus_rdata = {31'd0, tgt_q};
    else if (bus_addr == A_ADDR) bus_rdata = {{(32-PADDR_W){1'b0}}, addr_q};
    else if (bus_addr == A_STAT) bus_rdata = {29'd0, err_q, st};
    else if (bus_addr == A_LVL)  bus_rdata = {{(32-LVL_W){1'b0}}, lvl_q};
  end

  assign eng_start     = start_q;
  assign eng_line_code = line_q;
  assign eng_target    = tgt_q;
  assign eng_addr      = addr_q;
  assign eng_level     = lvl_q;
  assign eng_plain     = pt_q;
  assign res_valid     = (st == S_SHOWN);
  assign res_data      = res_valid ? res_q : '0;

  // R1/R2/R4/R5: status only steps forward around the ring
  a_r1_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> (2'(st) == 2'(2'($past(st)) + 2'd1)));
  a_r2_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (st == S_BUSY) && $past(st) == S_IDLE);
  a_r3_done_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIDDEN && $past(st) == S_BUSY) |-> $past(eng_done));
  a_r4_publish_from_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(st) == S_HIDDEN);
  a_r5_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> (res_q == '0));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clr)) |-> err_q);
  a_r9_params_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != S_IDLE) |-> $stable(addr_q) && $stable(line_q) && $stable(pt_q));
endmodule

// File: tb/mcrypt_seq_bench.sv
module mcrypt_seq_bench;
  localparam int LAT = 20;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] bus_be = '0;
  logic eng_start, eng_target, eng_done, res_valid;
  logic [1:0] eng_line_code;
  logic [25:0] eng_addr;
  logic [2:0] eng_level;
  logic [511:0] eng_plain, eng_result, res_data;
  logic done_m = 0, spur = 0;
  logic [511:0] res_m = '0;
  int cnt = 0, starts = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign eng_done = done_m | spur;
  assign eng_result = res_m;

  mcrypt_seq u_mcrypt_seq (.*);

  function automatic logic [511:0] model(logic [511:0] p, logic [25:0] a, logic [2:0] l);
    return p ^ {16{{6'd0, a}}} ^ {64{{5'd0, l}}};
  endfunction

  always @(posedge clk) begin
    done_m <= 1'b0;
    if (eng_start) begin
      cnt <= LAT; starts <= starts + 1;
      res_m <= model(eng_plain, eng_addr, eng_level);
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) done_m <= 1'b1;
    end
  end

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk); bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic stat_is(string req, logic [2:0] exp);
    logic [31:0] d;
    rd(12'h350, d);
    chk(req, 512'(d), 512'(exp));
  endtask

  task automatic wait_hidden();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(12'h350, d);
      if (d[1:0] == 2'd2) break;
    end
  endtask

  task automatic load(logic [511:0] p, logic [1:0] code, logic [25:0] a, logic [2:0] l);
    for (int w = 0; w < 16; w++) wr(12'h300 + 12'(w*4), p[w*32 +: 32]);
    wr(12'h340, 32'(code)); wr(12'h344, 0); wr(12'h348, 32'(a)); wr(12'h354, 32'(l));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [511:0] p, exp_res;
    logic [25:0] a;
    logic [1:0] code;
    logic [2:0] l;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    stat_is("R1 status", 3'd0);
    rd(12'h354, d); chk("R1 level", 512'(d), 512'd7);
    rd(12'h340, d); chk("R1 line", 512'(d), 0);
    rd(12'h348, d); chk("R1 addr", 512'(d), 0);
    rd(12'h344, d); chk("R1 target", 512'(d), 0);
    chk("R1 res_valid", 512'(res_valid), 0);
    // R9 strobed plaintext
    wr(12'h304, 32'hAABBCCDD);
    wr(12'h304, 32'h11223344, 4'b0101);
    rd(12'h304, d); chk("R9 strobes", 512'(d), 512'(32'hAA22CC44));
    // R6 wrong-state commands and clear
    wr(12'h34C, 32'h2); stat_is("R6 publish in idle", 3'b100);
    wr(12'h350, 32'h4); stat_is("R6 clear", 3'd0);
    wr(12'h34C, 32'h4); stat_is("R6 wipe in idle", 3'b100);
    wr(12'h350, 32'h4);
    // R7 illegal operands
    wr(12'h340, 32'd3); wr(12'h34C, 1); stat_is("R7 reserved code", 3'b100);
    wr(12'h350, 4); wr(12'h340, 32'd1); wr(12'h348, 32'h10);
    wr(12'h34C, 1); stat_is("R7 misaligned", 3'b100);
    wr(12'h350, 4); wr(12'h348, 32'h20); wr(12'h344, 1);
    wr(12'h34C, 1); stat_is("R7 target reserved", 3'b100);
    wr(12'h350, 4); wr(12'h344, 0);
    chk("R7 no start", 512'(starts), 0);
    // R3 stray done in idle
    @(negedge clk); spur = 1; @(negedge clk); spur = 0;
    stat_is("R3 stray done", 3'd0);
    chk("R3 stray res", res_data, 0);
    // R8 command reads zero
    rd(12'h34C, d); chk("R8 cmd read", 512'(d), 0);
    // directed full sequence
    p = '0; for (int w = 0; w < 16; w++) p[w*32 +: 32] = 32'h01010101 * (w + 1);
    load(p, 2'd2, 26'h3FFFFC0, 3'd0);
    wr(12'h34C, 1);
    chk("R2 eng_start", 512'(eng_start), 1);
    chk("R2 eng_plain", eng_plain, p);
    chk("R2 eng_addr", 512'(eng_addr), 512'(26'h3FFFFC0));
    chk("R10 eng_level", 512'(eng_level), 0);
    chk("R2 eng_line_code", 512'(eng_line_code), 2);
    @(negedge clk); chk("R2 pulse width", 512'(eng_start), 0);
    stat_is("R2 busy", 3'd1);
    wr(12'h34C, 1); stat_is("R6 start while busy", 3'b101);
    wr(12'h350, 4);
    wr(12'h340, 0); rd(12'h340, d); chk("R9 param frozen", 512'(d), 2);
    wr(12'h300, 32'hDEADBEEF); rd(12'h300, d); chk("R9 pt frozen", 512'(d), 512'(p[31:0]));
    chk("R2 single start", 512'(starts), 1);
    wait_hidden();
    stat_is("R3 hidden", 3'd2);
    chk("R3 res_valid low", 512'(res_valid), 0);
    chk("R3 res_data zero", res_data, 0);
    wr(12'h34C, 2); stat_is("R4 shown", 3'd3);
    chk("R4 res_valid", 512'(res_valid), 1);
    chk("R4 res_data", res_data, model(p, 26'h3FFFFC0, 3'd0));
    wr(12'h34C, 4); stat_is("R5 idle", 3'd0);
    chk("R5 res_valid low", 512'(res_valid), 0);
    chk("R5 res_data", res_data, 0);
    // random passes
    for (int it = 0; it < 30; it++) begin
      for (int w = 0; w < 16; w++) p[w*32 +: 32] = $urandom;
      code = 2'($urandom_range(0, 2));
      a = 26'($urandom);
      a = a & ~(26'(16 << code) - 26'd1);
      l = 3'($urandom_range(0, 7));
      load(p, code, a, l);
      exp_res = model(p, a, l);
      wr(12'h34C, 1);
      chk("R2 rand start", 512'(eng_start), 1);
      chk("R10 rand level", 512'(eng_level), 512'(l));
      wait_hidden();
      stat_is("R3 rand hidden", 3'd2);
      if ($urandom_range(0, 1) == 0) wr(12'h34C, 4); else wr(12'h34C, 1);
      stat_is("R6 rand wrong cmd", 3'b110);
      wr(12'h350, 4);
      wr(12'h34C, 2);
      chk("R4 rand result", res_data, exp_res);
      wr(12'h34C, 4);
      stat_is("R5 rand wipe", 3'd0);
      chk("R5 rand cleared", res_data, 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule